// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a serial memory that sits on a two-wire (I2C-style) bus. It synchronises the raw clock and data lines into the system clock domain, detects start and stop conditions, and checks the device address byte. The upper four bits of that byte must equal a fixed code, and the next three bits must equal three strap inputs. It then collects a two-byte word address and acknowledges or refuses each byte on the ninth clock. The receiving device pulls the data line low on the ninth clock to acknowledge.

After a write header, the word address goes to an external address counter as a one-cycle pulse. Every later data byte goes to a write engine over a valid/ready stream. A stop that closes a write with accepted data tells the engine to commit. Read bytes come from the address counter over a second valid/ready stream and are shifted out MSB first. A random read is a write header carrying the word address, then a repeated start and a read header.

While the write engine reports busy, the block refuses its own address, so the master can poll until the write is done. A start condition seen at any moment, even in the middle of a byte, drops the current transfer and begins a new address phase.

Back-pressure rules:
- Write stream: `wr_valid` rises after the eighth bit of a data byte and stays high with `wr_data` stable until `wr_ready` is seen. If the byte has not been accepted by the falling clock edge that opens the ninth bit, the offer is withdrawn and the byte is refused.
- Read stream: `rd_ready` stays high until `rd_valid` is seen. If no byte has arrived by the falling edge where its first bit is due, the block sends all ones for that byte.

Top module: `tws_eeprom_front`

## Requirements
- R1: After reset, `sda_oe`, `wa_valid`, `wr_valid`, `wr_commit` and `rd_ready` are all low.
- R2: An address byte is accepted only if bits 7..4 are 1010 and bits 3..1 equal `dev_sel[2:0]` (bit 3 = `dev_sel[2]`). Bit 0 selects read (1) or write (0). On a match the block drives SDA low for the whole ninth clock. On a mismatch it leaves SDA released and ignores the bus until the next start.
- R3: If `wr_busy` is high when the address acknowledge is decided, the address byte is refused whatever its R/W bit.
- R4: After a write header, two word-address bytes are each acknowledged. `wa_valid` then pulses for exactly one cycle, with `wa_addr` holding the low ADDR_W bits of {first byte, second byte}. The upper bits of the first byte are don't-care.
- R5: Each following write byte is offered on `wr_valid`/`wr_data` and held until `wr_ready`. A byte accepted before its ninth clock is acknowledged. Otherwise it is refused, and the rest of the transfer is ignored.
- R6: `wr_commit` pulses for one cycle at a stop that ends a write with at least one accepted data byte. It does not pulse after an address-only write or a read.
- R7: In a read, `rd_ready` asks for a byte at the read-header acknowledge and again after each master acknowledge. Bits go out MSB first, and `sda_oe` changes only after a synchronised SCL falling edge or on a start or stop.
- R8: A master no-acknowledge ends the read. SDA stays released and no further byte is requested.
- R9: If no read byte has arrived when its first bit is due, the byte sent is 8'hFF.
- R10: A start at any point, including mid-byte, restarts the address phase. A partly received word address produces no `wa_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line (wired level) |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| dev_sel | input | 3 | Strap value compared with address bits 3..1 |
| wr_busy | input | 1 | Write engine busy; refuses the address |
| wa_valid | output | 1 | One-cycle pulse: new word address |
| wa_addr | output | ADDR_W | Word address loaded into the counter |
| wr_valid | output | 1 | Write byte offered |
| wr_ready | input | 1 | Write engine accepts the byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | One-cycle pulse: start programming |
| rd_valid | input | 1 | Read byte available |
| rd_ready | output | 1 | Block requests a read byte |
| rd_data | input | 8 | Read byte from the address counter |

## Verification
A wrong internal state in this block shows at the ports within one bit time. An acknowledge appears in the wrong slot, or is missing from the right one. A read byte comes out with shifted or inverted bits. `wa_valid` fires with a wrong address, or fires after an aborted header. The bench drives complete bus transfers with a bit-level master model and reads back the acknowledge level and the read bytes from the wired SDA. A small address-counter model compares the bytes the block requests and delivers against the address it loaded, so an off-by-one in request timing shows up as a wrong byte value.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WAH,
    ST_WAL,
    ST_WDAT,
    ST_RDAT
  } tws_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-1:0], din[i]};
    end
    assign dout[i] = pipe[STAGES-1];
    assign rise[i] = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall[i] = ~pipe[STAGES-1] & pipe[STAGES];
  end
endmodule

// File: rtl/tws_cond.sv
module tws_cond (
  input  logic scl_s,
  input  logic scl_rise,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_o,
  output logic stop_o
);
  logic scl_steady_high;
  assign scl_steady_high = scl_s & ~scl_rise;
  assign start_o = scl_steady_high & sda_fall;
  assign stop_o  = scl_steady_high & sda_rise;
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        dev_sel,
  input  logic              wr_busy,
  input  logic              wr_ready,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  output logic              sda_oe,
  output logic              wa_valid,
  output logic [ADDR_W-1:0] wa_addr,
  output logic              wr_valid,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic              rd_ready
);
  localparam logic [3:0] FULL_CNT = 4'(BYTE_BITS);

  tws_state_e        st;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic              ack_ph;
  logic              oe;
  logic [7:0]        wa_hi;
  logic              wa_pulse;
  logic [ADDR_W-1:0] wa_q;
  logic              wv;
  logic [7:0]        wd;
  logic              w_taken;
  logic              wrote;
  logic              commit;
  logic              rd_want;
  logic              have;
  logic [7:0]        txb;
  logic [7:0]        tsh;
  logic              mack;

  logic       addr_hit;
  logic       w_accept;
  logic       rd_take;
  logic [7:0] next_bits;

  assign addr_hit  = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == dev_sel);
  assign w_accept  = w_taken | (wv & wr_ready);
  assign rd_take   = rd_want & rd_valid;
  assign next_bits = have ? txb : (rd_take ? rd_data : 8'hFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      ack_ph   <= 1'b0;
      oe       <= 1'b0;
      wa_hi    <= '0;
      wa_pulse <= 1'b0;
      wa_q     <= '0;
      wv       <= 1'b0;
      wd       <= '0;
      w_taken  <= 1'b0;
      wrote    <= 1'b0;
      commit   <= 1'b0;
      rd_want  <= 1'b0;
      have     <= 1'b0;
      txb      <= '0;
      tsh      <= '1;
      mack     <= 1'b0;
    end else begin
      wa_pulse <= 1'b0;
      commit   <= 1'b0;
      if (rd_take) begin
        txb     <= rd_data;
        have    <= 1'b1;
        rd_want <= 1'b0;
      end
      if (wv && wr_ready) begin
        wv      <= 1'b0;
        w_taken <= 1'b1;
      end
      if (start_i || stop_i) begin
        st      <= start_i ? ST_DEV : ST_IDLE;
        bitcnt  <= '0;
        ack_ph  <= 1'b0;
        oe      <= 1'b0;
        wv      <= 1'b0;
        w_taken <= 1'b0;
        rd_want <= 1'b0;
        have    <= 1'b0;
        wrote   <= 1'b0;
        commit  <= stop_i & wrote;
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_DEV, ST_WAH, ST_WAL, ST_WDAT: begin
            if (!ack_ph) begin
              if (scl_rise && bitcnt != FULL_CNT) begin
                shreg  <= {shreg[6:0], sda_s};
                bitcnt <= bitcnt + 4'd1;
                if (st == ST_WDAT && bitcnt == FULL_CNT - 4'd1) begin
                  wv      <= 1'b1;
                  wd      <= {shreg[6:0], sda_s};
                  w_taken <= 1'b0;
                end
              end else if (scl_fall && bitcnt == FULL_CNT) begin
                bitcnt <= '0;
                unique case (st)
                  ST_DEV: begin
                    if (addr_hit && !wr_busy) begin
                      oe     <= 1'b1;
                      ack_ph <= 1'b1;
                      if (shreg[0]) rd_want <= 1'b1;
                    end else begin
                      st <= ST_IDLE;
                    end
                  end
                  ST_WAH: begin
                    wa_hi  <= shreg;
                    oe     <= 1'b1;
                    ack_ph <= 1'b1;
                  end
                  ST_WAL: begin
                    wa_q     <= ADDR_W'({wa_hi, shreg});
                    wa_pulse <= 1'b1;
                    oe       <= 1'b1;
                    ack_ph   <= 1'b1;
                  end
                  default: begin
                    wv <= 1'b0;
                    if (w_accept) begin
                      oe     <= 1'b1;
                      ack_ph <= 1'b1;
                      wrote  <= 1'b1;
                    end else begin
                      st <= ST_IDLE;
                    end
                  end
                endcase
              end
            end else if (scl_fall) begin
              ack_ph <= 1'b0;
              oe     <= 1'b0;
              unique case (st)
                ST_DEV: begin
                  if (shreg[0]) begin
                    st     <= ST_RDAT;
                    oe     <= ~next_bits[7];
                    tsh    <= {next_bits[6:0], 1'b1};
                    have   <= 1'b0;
                    bitcnt <= '0;
                  end else begin
                    st <= ST_WAH;
                  end
                end
                ST_WAH:  st <= ST_WAL;
                default: st <= ST_WDAT;
              endcase
            end
          end
          ST_RDAT: begin
            if (!ack_ph) begin
              if (scl_rise && bitcnt != FULL_CNT) begin
                bitcnt <= bitcnt + 4'd1;
              end else if (scl_fall) begin
                if (bitcnt == FULL_CNT) begin
                  oe     <= 1'b0;
                  ack_ph <= 1'b1;
                  bitcnt <= '0;
                end else begin
                  oe  <= ~tsh[7];
                  tsh <= {tsh[6:0], 1'b1};
                end
              end
            end else begin
              if (scl_rise) begin
                mack <= ~sda_s;
                if (!sda_s) rd_want <= 1'b1;
              end else if (scl_fall) begin
                ack_ph <= 1'b0;
                if (mack) begin
                  oe   <= ~next_bits[7];
                  tsh  <= {next_bits[6:0], 1'b1};
                  have <= 1'b0;
                end else begin
                  st <= ST_IDLE;
                  oe <= 1'b0;
                end
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe    = oe;
  assign wa_valid  = wa_pulse;
  assign wa_addr   = wa_q;
  assign wr_valid  = wv;
  assign wr_data   = wd;
  assign wr_commit = commit;
  assign rd_ready  = rd_want;

  // R7: SDA enable only moves after a clock fall or on a bus condition
  assert_oe_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_s) && !$past(start_i) && !$past(stop_i)) |-> $stable(oe));

  // R3: busy turns the address acknowledge into a refusal
  assert_busy_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEV && !ack_ph && scl_fall && bitcnt == FULL_CNT && wr_busy && !start_i && !stop_i)
      |=> !oe);

  // R4: word-address strobe lasts one cycle
  assert_wa_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wa_pulse |=> !wa_pulse);

  // R5: an offered write byte stays put until taken or withdrawn
  assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wv && !wr_ready && !scl_fall && !start_i && !stop_i) |=> (wv && $stable(wd)));

  // R6: commit strobe lasts one cycle
  assert_commit_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  // R10: a start returns to the address phase with SDA released
  assert_start_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (st == ST_DEV && !oe && bitcnt == 4'd0));
endmodule

// File: rtl/tws_eeprom_front.sv
module tws_eeprom_front #(
  parameter int ADDR_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [2:0]        dev_sel,
  input  logic              wr_busy,
  output logic              wa_valid,
  output logic [ADDR_W-1:0] wa_addr,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [7:0]        rd_data
);
  localparam int LINES = 2;

  logic [LINES-1:0] line_s, line_r, line_f;
  logic start_c, stop_c;

  tws_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_in, sda_in}),
    .dout (line_s),
    .rise (line_r),
    .fall (line_f)
  );

  tws_cond u_cond (
    .scl_s   (line_s[1]),
    .scl_rise(line_r[1]),
    .sda_rise(line_r[0]),
    .sda_fall(line_f[0]),
    .start_o (start_c),
    .stop_o  (stop_c)
  );

  tws_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (line_s[1]),
    .sda_s    (line_s[0]),
    .scl_rise (line_r[1]),
    .scl_fall (line_f[1]),
    .start_i  (start_c),
    .stop_i   (stop_c),
    .dev_sel  (dev_sel),
    .wr_busy  (wr_busy),
    .wr_ready (wr_ready),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .wa_valid (wa_valid),
    .wa_addr  (wa_addr),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .wr_commit(wr_commit),
    .rd_ready (rd_ready)
  );
endmodule

// File: tb/sim_tws_eeprom_front.sv
module sim_tws_eeprom_front;
  localparam int ADDR_W = 13;
  localparam int Q = 4;
  // {expected ack, address byte} with dev_sel = 3'b101
  localparam logic [8:0] VEC [0:6] = '{9'h1AA, 9'h1AB, 9'h0A2, 9'h0BA, 9'h02A, 9'h0AE, 9'h0A8};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [2:0] dev_sel = 3'b101;
  logic wr_busy = 1'b0;
  logic wa_valid;
  logic [ADDR_W-1:0] wa_addr;
  logic wr_valid;
  logic wr_ready = 1'b1;
  logic [7:0] wr_data;
  logic wr_commit;
  logic rd_valid = 1'b1;
  logic rd_ready;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  tws_eeprom_front #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .dev_sel(dev_sel), .wr_busy(wr_busy), .wa_valid(wa_valid), .wa_addr(wa_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_commit(wr_commit),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  // address-counter and write-engine model
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] last_wa;
  int wa_cnt, commit_cnt, wcnt;
  logic [7:0] wlog [0:15];
  assign rd_data = ptr[7:0] ^ 8'h5A;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0; last_wa <= '0; wa_cnt <= 0; commit_cnt <= 0; wcnt <= 0;
    end else begin
      if (wa_valid) begin
        ptr <= wa_addr; last_wa <= wa_addr; wa_cnt <= wa_cnt + 1;
      end else if (rd_valid && rd_ready) begin
        ptr <= ptr + 1'b1;
      end
      if (wr_valid && wr_ready) begin
        if (wcnt < 16) wlog[wcnt[3:0]] <= wr_data;
        wcnt <= wcnt + 1;
      end
      if (wr_commit) commit_cnt <= commit_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart;
    wt(Q); sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0;
  endtask

  task automatic bstop;
    wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(2*Q);
  endtask

  task automatic sbit(input logic b);
    wt(Q); sda_m = b; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0;
  endtask

  task automatic rbit(output logic b);
    wt(Q); sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); b = sda_bus; wt(Q); scl_m = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    sbit(~mack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    int wa0, cm0, w0;
    wt(5);
    rst_n = 1'b1;
    wt(4);
    // R1: idle outputs after reset
    chk("R1 reset outputs", {27'd0, sda_oe, wa_valid, wr_valid, wr_commit, rd_ready}, 32'd0);

    // R2: address matching table
    for (int v = 0; v < 7; v++) begin
      bstart;
      wbyte(VEC[v][7:0], a);
      chk($sformatf("R2 address %0h ack", VEC[v][7:0]), {31'd0, a}, {31'd0, VEC[v][8]});
      if (a && VEC[v][0]) rbyte(d, 1'b0);
      bstop;
    end

    // R4/R5/R6: write with word address
    wa0 = wa_cnt; cm0 = commit_cnt; w0 = wcnt;
    bstart;
    wbyte(8'hAA, a); chk("R2 write header ack", {31'd0, a}, 32'd1);
    wbyte(8'hE1, a); chk("R4 first word byte ack", {31'd0, a}, 32'd1);
    wbyte(8'h23, a); chk("R4 second word byte ack", {31'd0, a}, 32'd1);
    wt(2);
    chk("R4 one address strobe", wa_cnt - wa0, 32'd1);
    chk("R4 word address value", {19'd0, last_wa}, 32'h0123);
    wbyte(8'h11, a); chk("R5 data0 ack", {31'd0, a}, 32'd1);
    wbyte(8'h22, a); chk("R5 data1 ack", {31'd0, a}, 32'd1);
    wbyte(8'h33, a); chk("R5 data2 ack", {31'd0, a}, 32'd1);
    chk("R5 bytes delivered", wcnt - w0, 32'd3);
    chk("R5 byte order", {8'd0, wlog[w0], wlog[w0+1], wlog[w0+2]}, 32'h112233);
    bstop;
    chk("R6 commit after write", commit_cnt - cm0, 32'd1);

    // R3: busy polling
    wr_busy = 1'b1;
    bstart; wbyte(8'hAA, a); chk("R3 busy write header refused", {31'd0, a}, 32'd0); bstop;
    bstart; wbyte(8'hAB, a); chk("R3 busy read header refused", {31'd0, a}, 32'd0); bstop;
    wr_busy = 1'b0;
    cm0 = commit_cnt;
    bstart; wbyte(8'hAA, a); chk("R3 ack after busy clears", {31'd0, a}, 32'd1); bstop;
    chk("R6 no commit on address-only write", commit_cnt - cm0, 32'd0);

    // R7/R8: random read with sequential bytes
    cm0 = commit_cnt;
    bstart;
    wbyte(8'hAA, a);
    wbyte(8'h00, a);
    wbyte(8'h40, a);
    bstart;
    wbyte(8'hAB, a); chk("R7 read header ack", {31'd0, a}, 32'd1);
    rbyte(d, 1'b1); chk("R7 read byte 0", {24'd0, d}, {24'd0, 8'h40 ^ 8'h5A});
    rbyte(d, 1'b1); chk("R7 read byte 1", {24'd0, d}, {24'd0, 8'h41 ^ 8'h5A});
    rbyte(d, 1'b0); chk("R7 read byte 2", {24'd0, d}, {24'd0, 8'h42 ^ 8'h5A});
    wt(Q);
    chk("R8 no request after nack", {31'd0, rd_ready}, 32'd0);
    chk("R8 sda released after nack", {31'd0, sda_oe}, 32'd0);
    bstop;
    chk("R6 no commit after read", commit_cnt - cm0, 32'd0);

    // R7: current-address read continues from counter
    bstart;
    wbyte(8'hAB, a);
    rbyte(d, 1'b0); chk("R7 current address read", {24'd0, d}, {24'd0, 8'h43 ^ 8'h5A});
    bstop;

    // R9: no read byte supplied
    rd_valid = 1'b0;
    bstart;
    wbyte(8'hAB, a); chk("R9 header ack", {31'd0, a}, 32'd1);
    rbyte(d, 1'b0); chk("R9 empty byte is all ones", {24'd0, d}, 32'h0FF);
    bstop;
    rd_valid = 1'b1;
    chk("R9 request dropped at stop", {31'd0, rd_ready}, 32'd0);

    // R5: write engine not ready
    wr_ready = 1'b0;
    w0 = wcnt; cm0 = commit_cnt;
    bstart;
    wbyte(8'hAA, a);
    wbyte(8'h00, a);
    wbyte(8'h10, a);
    wbyte(8'h77, a); chk("R5 unaccepted byte refused", {31'd0, a}, 32'd0);
    chk("R5 withdrawn offer", {31'd0, wr_valid}, 32'd0);
    bstop;
    wr_ready = 1'b1;
    chk("R5 nothing delivered", wcnt - w0, 32'd0);
    chk("R6 no commit when refused", commit_cnt - cm0, 32'd0);

    // R10: start in the middle of a word-address byte
    wa0 = wa_cnt;
    bstart;
    wbyte(8'hAA, a);
    for (int i = 0; i < 4; i++) sbit(1'b0);
    bstart;
    wbyte(8'hAB, a); chk("R10 header after mid-byte start", {31'd0, a}, 32'd1);
    rbyte(d, 1'b0); chk("R10 counter untouched", {24'd0, d}, {24'd0, 8'h10 ^ 8'h5A});
    bstop;
    chk("R10 no address strobe from partial header", wa_cnt - wa0, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule